// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block is a register-mapped pulse-width generator with four independent output channels. A host reaches it through a simple synchronous bus: an address, a write strobe, write data and read data. The channel index sits in the upper address bits, and each channel owns a 32-byte window. Every channel divides the source clock by a programmable prescaler. It then counts a programmable number of prescaled ticks per period and drives its output high for a programmable number of those ticks.

The prescale, modulus and duty settings are written into holding registers. Writing the duty register arms a commit. If the channel is stopped, the commit applies on the next clock. If the channel is running, it waits for the current period to end, so no period ever mixes old and new settings. Clearing the enable bit stops a channel at once: its output goes low and its counters return to zero. Setting enable starts a fresh period with the last committed settings.

Top module: `pwm_bank`

## Requirements
- R1: The channel index is taken from address bits [6:5]. Inside a window, the byte offsets are 0x00 for prescale, 0x04 for modulus, 0x08 for duty and 0x18 for enable. Each channel's registers are separate from those of the other channels.
- R2: Reads return the most recently written field values on the same cycle the address is presented: prescale in bits [7:0], modulus in bits [7:0], duty in bits [15:0] and enable in bit 0. All other read bits are zero, and write bits outside a field are dropped.
- R3: A read from any other offset in a window returns zero, and a write to it changes no register and no output.
- R4: A running channel with prescale P, modulus M (M > 0) and duty D (0 < D < M) repeats a period of (P+1)*M clock cycles. The output is high for the first (P+1)*D cycles of each period.
- R5: Writing prescale or modulus without a later duty write leaves the output waveform unchanged.
- R6: A duty write to a running channel takes effect only at the next period boundary. For the rest of the current period, the output follows the old settings.
- R7: On the clock edge that writes 0 to the enable bit, the output goes low and stays low while the channel is disabled. This does not wait for the period to end.
- R8: A duty write to a disabled channel commits on the next clock. Setting enable starts a new period at count zero: the output is high from the cycle after the enable write for (P+1)*D cycles.
- R9: If D >= M with M > 0, the output stays high without a break. If D = 0 or M = 0, the output stays low.
- R10: After reset, every output is low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for the bus and the counters |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 7 | Byte address: channel in [6:5], register offset in [4:0] |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the presented address, combinational |
| pwm_out | output | 4 | One waveform output per channel |

## Verification
Read data is combinational, so the bench presents an address and samples the read bus one time step later, well before the next edge. A write lands on the rising edge between two falling edges. Because the counters are already at zero while a channel is stopped, the output reflects an enable, a disable or an immediate commit at the next falling-edge sample. Every output check is taken on falling edges and counted from that first sample. A deferred commit shows up only at the first rising output after the running period's last tick. To test that, the bench lines each write up with a known count position and checks the output both before and after the boundary.

// File: rtl/pwm_bank_pkg.sv
// Package: shared constants, register selector type and offset decoder
// for the multi-channel PWM bank.
// Assumes: every channel window is 2**WIN_SHIFT bytes and register offsets
// are matched exactly, so unaligned offsets decode as unmapped.
package pwm_bank_pkg;

    localparam int WIN_SHIFT = 5;

    localparam logic [WIN_SHIFT-1:0] OFF_PRESCALE = 5'h00;
    localparam logic [WIN_SHIFT-1:0] OFF_MODULUS  = 5'h04;
    localparam logic [WIN_SHIFT-1:0] OFF_DUTY     = 5'h08;
    localparam logic [WIN_SHIFT-1:0] OFF_ENABLE   = 5'h18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PRESCALE,
        SEL_MODULUS,
        SEL_DUTY,
        SEL_ENABLE
    } reg_sel_e;

    // Map an in-window byte offset onto a register selector.
    function automatic reg_sel_e decode_offset(input logic [WIN_SHIFT-1:0] off);
        reg_sel_e sel;
        case (off)
            OFF_PRESCALE: sel = SEL_PRESCALE;
            OFF_MODULUS:  sel = SEL_MODULUS;
            OFF_DUTY:     sel = SEL_DUTY;
            OFF_ENABLE:   sel = SEL_ENABLE;
            default:      sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/pwm_bank_decode.sv
// Module: bus decoder for the PWM bank.
// Turns a bus write into one per-channel, per-register write strobe and
// multiplexes the addressed channel's readback fields onto the read bus.
// Assumes: reads are combinational; unmapped offsets and out-of-range
// channel indices read zero and produce no strobe.
module pwm_bank_decode
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    parameter int PRE_W  = 8,
    parameter int MOD_W  = 8,
    parameter int DUTY_W = 16,
    parameter int ADDR_W = WIN_SHIFT + $clog2(NUM_CH)
) (
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic [NUM_CH-1:0][PRE_W-1:0]  rd_pre,
    input  logic [NUM_CH-1:0][MOD_W-1:0]  rd_mod,
    input  logic [NUM_CH-1:0][DUTY_W-1:0] rd_duty,
    input  logic [NUM_CH-1:0]             rd_en,
    output logic [NUM_CH-1:0]             wr_pre,
    output logic [NUM_CH-1:0]             wr_mod,
    output logic [NUM_CH-1:0]             wr_duty,
    output logic [NUM_CH-1:0]             wr_en,
    output logic [DATA_W-1:0]             bus_rdata
);

    localparam int CH_W = ADDR_W - WIN_SHIFT;

    logic [CH_W-1:0] ch_idx;
    logic            ch_ok;
    reg_sel_e        sel;

    assign ch_idx = bus_addr[ADDR_W-1:WIN_SHIFT];
    assign ch_ok  = (int'(ch_idx) < NUM_CH);
    assign sel    = decode_offset(bus_addr[WIN_SHIFT-1:0]);

    // One strobe per channel and register, raised only for a mapped write.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
        logic hit;
        assign hit        = bus_wr && (ch_idx == CH_W'(g));
        assign wr_pre[g]  = hit && (sel == SEL_PRESCALE);
        assign wr_mod[g]  = hit && (sel == SEL_MODULUS);
        assign wr_duty[g] = hit && (sel == SEL_DUTY);
        assign wr_en[g]   = hit && (sel == SEL_ENABLE);
    end

    // Read multiplexer: zero-extended field of the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (ch_ok) begin
            case (sel)
                SEL_PRESCALE: bus_rdata = DATA_W'(rd_pre[ch_idx]);
                SEL_MODULUS:  bus_rdata = DATA_W'(rd_mod[ch_idx]);
                SEL_DUTY:     bus_rdata = DATA_W'(rd_duty[ch_idx]);
                SEL_ENABLE:   bus_rdata = DATA_W'(rd_en[ch_idx]);
                default:      bus_rdata = '0;
            endcase
        end
    end

    // R3
    always_comb begin
        if (!bus_wr) begin
            no_idle_strobe_chk: assert ((wr_pre | wr_mod | wr_duty | wr_en) == '0);
        end
    end

    // R1
    always_comb begin
        onehot_strobe_chk: assert ($onehot0({wr_pre, wr_mod, wr_duty, wr_en}));
    end

endmodule

// File: rtl/pwm_chan_regs.sv
// Module: register set of one PWM channel.
// Holds the host-visible holding copies of prescale, modulus and duty,
// the enable bit, a commit-pending flag and the active copies used by the
// counter. A duty write arms the commit. The commit applies at once while
// the channel is stopped, and otherwise on the period boundary flagged by
// the counter.
// Assumes: wdata is at least as wide as every field; readback shows the
// holding copies.
module pwm_chan_regs #(
    parameter int PRE_W  = 8,
    parameter int MOD_W  = 8,
    parameter int DUTY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pre,
    input  logic              wr_mod,
    input  logic              wr_duty,
    input  logic              wr_en,
    input  logic [DUTY_W-1:0] wdata,
    input  logic              boundary,
    output logic [PRE_W-1:0]  sh_pre,
    output logic [MOD_W-1:0]  sh_mod,
    output logic [DUTY_W-1:0] sh_duty,
    output logic              en,
    output logic [PRE_W-1:0]  act_pre,
    output logic [MOD_W-1:0]  act_mod,
    output logic [DUTY_W-1:0] act_duty
);

    logic pending;
    logic commit;

    assign commit = pending && (!en || boundary);

    // Host writes into holding registers and the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_pre  <= '0;
            sh_mod  <= '0;
            sh_duty <= '0;
            en      <= 1'b0;
        end else begin
            if (wr_pre)  sh_pre  <= wdata[PRE_W-1:0];
            if (wr_mod)  sh_mod  <= wdata[MOD_W-1:0];
            if (wr_duty) sh_duty <= wdata;
            if (wr_en)   en      <= wdata[0];
        end
    end

    // Commit flag: armed by a duty write, cleared once the commit lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (wr_duty) begin
            pending <= 1'b1;
        end else if (commit) begin
            pending <= 1'b0;
        end
    end

    // Active settings: copied from the holding registers on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pre  <= '0;
            act_mod  <= '0;
            act_duty <= '0;
        end else if (commit) begin
            act_pre  <= sh_pre;
            act_mod  <= sh_mod;
            act_duty <= sh_duty;
        end
    end

    // R6
    period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !boundary) |=> ($stable(act_pre) && $stable(act_mod) && $stable(act_duty)));

    // R5
    shadow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> ($stable(act_pre) && $stable(act_mod) && $stable(act_duty)));

    // R8
    stopped_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !en && !wr_duty) |=> !pending);

endmodule

// File: rtl/pwm_chan_core.sv
// Module: waveform engine of one PWM channel.
// A prescale counter produces one tick every act_pre+1 cycles. A period
// counter steps on each tick from 0 to act_mod-1. The output is high while
// the period count is below act_duty. Both counters rest at zero while the
// channel is disabled.
// Assumes: the active settings change only when `boundary` is high or the
// channel is disabled (guaranteed by pwm_chan_regs).
module pwm_chan_core #(
    parameter int PRE_W  = 8,
    parameter int MOD_W  = 8,
    parameter int DUTY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PRE_W-1:0]  act_pre,
    input  logic [MOD_W-1:0]  act_mod,
    input  logic [DUTY_W-1:0] act_duty,
    output logic              boundary,
    output logic              pwm_o
);

    logic [PRE_W-1:0] pre_cnt;
    logic [MOD_W-1:0] per_cnt;
    logic             tick;
    logic             last;

    assign tick     = (pre_cnt == act_pre);
    assign last     = (act_mod == '0) || (per_cnt == MOD_W'(act_mod - 1'b1));
    assign boundary = en && tick && last;

    // Prescale and period counters; held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (!en) begin
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
            per_cnt <= last ? '0 : per_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // Output compare: high while the period count is below the duty value.
    assign pwm_o = en && (act_mod != '0) && (DUTY_W'(per_cnt) < act_duty);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && act_mod != '0) |-> (per_cnt < act_mod && pre_cnt <= act_pre));

    // R7
    stop_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pre_cnt == '0 && per_cnt == '0));

    // R9
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && act_mod != '0 && DUTY_W'(act_mod) <= act_duty) |-> pwm_o);

    // R9
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mod == '0 || act_duty == '0) |-> !pwm_o);

endmodule

// File: rtl/pwm_bank.sv
// Module: top of the multi-channel PWM bank.
// Joins the bus decoder to one register set and one waveform engine per
// channel, built by a generate loop.
// Assumes: DUTY_W is the widest field and is at most DATA_W; the reset is
// synchronous and active low.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    parameter int PRE_W  = 8,
    parameter int MOD_W  = 8,
    parameter int DUTY_W = 16,
    parameter int ADDR_W = WIN_SHIFT + $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0][PRE_W-1:0]  rd_pre;
    logic [NUM_CH-1:0][MOD_W-1:0]  rd_mod;
    logic [NUM_CH-1:0][DUTY_W-1:0] rd_duty;
    logic [NUM_CH-1:0]             rd_en;
    logic [NUM_CH-1:0]             wr_pre;
    logic [NUM_CH-1:0]             wr_mod;
    logic [NUM_CH-1:0]             wr_duty;
    logic [NUM_CH-1:0]             wr_en;
    logic [DUTY_W-1:0]             wfield;
    logic                          unused_wdata_hi;

    assign wfield          = bus_wdata[DUTY_W-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:DUTY_W];

    pwm_bank_decode #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .PRE_W  (PRE_W),
        .MOD_W  (MOD_W),
        .DUTY_W (DUTY_W),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .rd_pre    (rd_pre),
        .rd_mod    (rd_mod),
        .rd_duty   (rd_duty),
        .rd_en     (rd_en),
        .wr_pre    (wr_pre),
        .wr_mod    (wr_mod),
        .wr_duty   (wr_duty),
        .wr_en     (wr_en),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic [PRE_W-1:0]  act_pre;
        logic [MOD_W-1:0]  act_mod;
        logic [DUTY_W-1:0] act_duty;
        logic              boundary;

        pwm_chan_regs #(
            .PRE_W  (PRE_W),
            .MOD_W  (MOD_W),
            .DUTY_W (DUTY_W)
        ) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_pre   (wr_pre[g]),
            .wr_mod   (wr_mod[g]),
            .wr_duty  (wr_duty[g]),
            .wr_en    (wr_en[g]),
            .wdata    (wfield),
            .boundary (boundary),
            .sh_pre   (rd_pre[g]),
            .sh_mod   (rd_mod[g]),
            .sh_duty  (rd_duty[g]),
            .en       (rd_en[g]),
            .act_pre  (act_pre),
            .act_mod  (act_mod),
            .act_duty (act_duty)
        );

        pwm_chan_core #(
            .PRE_W  (PRE_W),
            .MOD_W  (MOD_W),
            .DUTY_W (DUTY_W)
        ) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (rd_en[g]),
            .act_pre  (act_pre),
            .act_mod  (act_mod),
            .act_duty (act_duty),
            .boundary (boundary),
            .pwm_o    (pwm_out[g])
        );
    end

    // R7
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en & pwm_out) == pwm_out));

endmodule

// File: tb/pwm_bank_test.sv
// Directed bench for pwm_bank: one task per scenario, each checking its
// own results on falling-edge samples.
module pwm_bank_test;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwm_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [6:0] adr(input int ch, input int off);
        return 7'(ch * 32 + off);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int off, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = adr(ch, off);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int ch, input int off, output logic [31:0] d);
        @(negedge clk);
        bus_addr = adr(ch, off);
        #1;
        d = bus_rdata;
    endtask

    task automatic setup(input int ch, input int p, input int m, input int d);
        wr(ch, 'h18, 0);
        wr(ch, 'h00, p);
        wr(ch, 'h04, m);
        wr(ch, 'h08, d);
        wr(ch, 'h18, 1);
    endtask

    // Sync to a rising output, then count high and low samples of one period.
    task automatic measure(input int ch, input int ehi, input int elo, input string tag);
        int hi = 0;
        int lo = 0;
        int guard = 0;
        logic prev;
        prev = pwm_out[ch];
        @(negedge clk);
        while (!(prev == 1'b0 && pwm_out[ch] == 1'b1) && guard < 5000) begin
            prev = pwm_out[ch];
            @(negedge clk);
            guard++;
        end
        while (pwm_out[ch] == 1'b1 && hi < 5000) begin hi++; @(negedge clk); end
        while (pwm_out[ch] == 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
        check(hi == ehi, {tag, " high cycles"}, hi, ehi);
        check(lo == elo, {tag, " low cycles"}, lo, elo);
    endtask

    // Count samples over n cycles where output differs from the level.
    task automatic hold_level(input int ch, input logic lvl, input int n, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch] != lvl) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check(pwm_out == 4'b0, "R10 outputs low after reset", int'(pwm_out), 0);
        rd(0, 'h08, v);
        check(v == 0, "R10 duty reads zero", int'(v), 0);
        rd(3, 'h18, v);
        check(v == 0, "R10 enable reads zero", int'(v), 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(2, 'h00, 32'hFFFF_FF5A);
        wr(2, 'h04, 32'h0000_01C3);
        wr(2, 'h08, 32'hABCD_1234);
        wr(2, 'h18, 32'hFFFF_FFFE);
        rd(2, 'h00, v); check(v == 32'h5A, "R2 prescale field", int'(v), 'h5A);
        rd(2, 'h04, v); check(v == 32'hC3, "R2 modulus field", int'(v), 'hC3);
        rd(2, 'h08, v); check(v == 32'h1234, "R2 duty field", int'(v), 'h1234);
        rd(2, 'h18, v); check(v == 0, "R2 enable bit 0", int'(v), 0);
        rd(0, 'h00, v); check(v == 0, "R1 other window untouched", int'(v), 0);
        rd(1, 'h04, v); check(v == 0, "R1 channel 1 modulus separate", int'(v), 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(1, 'h0C, 32'hFFFF);
        wr(1, 'h1C, 1);
        wr(1, 'h19, 1);
        wr(1, 'h05, 32'h77);
        rd(1, 'h0C, v); check(v == 0, "R3 offset 0x0C reads zero", int'(v), 0);
        rd(1, 'h1C, v); check(v == 0, "R3 offset 0x1C reads zero", int'(v), 0);
        rd(1, 'h18, v); check(v == 0, "R3 enable not set by unmapped write", int'(v), 0);
        rd(1, 'h04, v); check(v == 0, "R3 modulus not set by unaligned write", int'(v), 0);
        check(pwm_out == 4'b0, "R3 outputs unaffected", int'(pwm_out), 0);
    endtask

    task automatic t_period();
        setup(0, 2, 5, 2);
        measure(0, 6, 9, "R4 P2 M5 D2");
        measure(0, 6, 9, "R4 repeat period");
    endtask

    task automatic t_shadow();
        logic [31:0] v;
        setup(1, 1, 4, 2);
        measure(1, 4, 4, "R4 P1 M4 D2");
        wr(1, 'h04, 8);
        wr(1, 'h00, 3);
        rd(1, 'h04, v); check(v == 8, "R2 modulus readback before commit", int'(v), 8);
        measure(1, 4, 4, "R5 modulus and prescale alone");
        measure(1, 4, 4, "R5 still old settings");
        wr(1, 'h08, 2);
        measure(1, 8, 24, "R5 duty write commits P3 M8 D2");
    endtask

    task automatic t_boundary();
        setup(0, 0, 10, 3);
        measure(0, 3, 7, "R4 P0 M10 D3");
        for (int i = 0; i < 4; i++) @(negedge clk);
        wr(0, 'h08, 7);
        check(pwm_out[0] == 1'b0, "R6 no mid-period change", int'(pwm_out[0]), 0);
        hold_level(0, 1'b0, 3, "R6 rest of old period low");
        measure(0, 7, 3, "R6 new duty after boundary");
    endtask

    task automatic t_stop_restart();
        measure(0, 7, 3, "R4 P0 M10 D7");
        // measure ended on a rising sample; move into the high phase
        check(pwm_out[0] == 1'b1, "R7 high before stop", int'(pwm_out[0]), 1);
        wr(0, 'h18, 0);
        check(pwm_out[0] == 1'b0, "R7 immediate stop", int'(pwm_out[0]), 0);
        hold_level(0, 1'b0, 5, "R7 stays low while disabled");
        wr(0, 'h08, 4);
        wr(0, 'h18, 1);
        begin
            int hi = 0;
            int lo = 0;
            while (pwm_out[0] == 1'b1 && hi < 100) begin hi++; @(negedge clk); end
            while (pwm_out[0] == 1'b0 && lo < 100) begin lo++; @(negedge clk); end
            check(hi == 4, "R8 fresh period high", hi, 4);
            check(lo == 6, "R8 fresh period low", lo, 6);
        end
        wr(0, 'h18, 0);
    endtask

    task automatic t_extremes();
        setup(3, 1, 4, 4);
        hold_level(3, 1'b1, 20, "R9 duty equal modulus high");
        wr(3, 'h08, 9);
        for (int i = 0; i < 12; i++) @(negedge clk);
        hold_level(3, 1'b1, 20, "R9 duty above modulus high");
        wr(3, 'h08, 0);
        for (int i = 0; i < 12; i++) @(negedge clk);
        hold_level(3, 1'b0, 20, "R9 duty zero low");
        wr(3, 'h04, 0);
        wr(3, 'h08, 3);
        for (int i = 0; i < 12; i++) @(negedge clk);
        hold_level(3, 1'b0, 20, "R9 modulus zero low");
        wr(3, 'h18, 0);
    endtask

    task automatic t_independent();
        logic [31:0] v;
        setup(2, 0, 6, 1);
        setup(3, 3, 3, 2);
        measure(2, 1, 5, "R1 channel 2 waveform");
        measure(3, 8, 4, "R1 channel 3 waveform");
        rd(2, 'h08, v); check(v == 1, "R1 channel 2 duty intact", int'(v), 1);
        rd(3, 'h04, v); check(v == 3, "R1 channel 3 modulus", int'(v), 3);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 100000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_unmapped();
        t_period();
        t_shadow();
        t_boundary();
        t_stop_restart();
        t_extremes();
        t_independent();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule